// File: doc/BRIEF.md
# Single-Channel Fly-By / Two-Cycle DMA Sequencer

This block is one DMA channel that becomes bus master to move a programmed number of data units from a source endpoint to a destination endpoint. Each endpoint has a programmed type. The channel compares the two types against a fixed legality table and then picks one of two transfer styles. In the fly-by style, one bus cycle moves one unit: the acknowledge strobe selects the external device, and the bus address selects the memory at the other end. In the two-cycle style, a read of the source fills an internal holding register, and a write to the destination follows.

Software sets up the channel through a small register-write port. That port loads the source address, the destination address, the unit count and a control word. Writing the control word with its go bit set starts the channel. Once running, the channel waits for the device request input. It then raises a request on the bus and moves units once the bus is granted. It keeps the bus until the count expires (burst) or gives the bus back after every unit (cycle-steal). When the last unit is moved, it raises a done flag and a one-cycle interrupt pulse. A configuration that is not allowed sets an error flag, and the channel does not start.

Top module: `dma_flyby_ch`

## Requirements
- R1: Endpoint type codes are 0 acknowledge-driven device, 1 external memory, 2 memory-mapped external device, 3 on-chip peripheral and 4 on-chip memory. Codes 5 to 7 are invalid. An acknowledge-driven device may pair only with code 1 or 2. Any other pairing that includes code 0, or any invalid code, sets `err`, leaves `busy` low and raises no bus request.
- R2: When either endpoint is code 3, the access size must equal the parameter `PERIPH_SIZE`. A different size sets `err` and the channel does not start. Sizes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R3: Starting with a unit count of zero sets `err` and the channel does not start.
- R4: When one endpoint is code 0, each unit takes exactly one bus access with `dack` high. `bus_addr` carries the other endpoint's address. The access is a write when the device is the source and a read when the device is the destination.
- R5: When neither endpoint is code 0, each unit is a read at the source address followed, in the next cycle, by a write at the destination address. The write data equals the data read. `dack` stays low.
- R6: After each unit, every address that is driven onto the bus steps by the access size according to its own mode. Mode 0 keeps it fixed, mode 1 increments it and mode 2 decrements it.
- R7: Each unit decrements the count. After the last unit, `done` goes high and `irq` is high for exactly one cycle.
- R8: In burst mode, `bus_req` stays high from the first unit to the last unit.
- R9: In cycle-steal mode, `bus_req` drops after every unit. The channel waits for `bus_gnt` to go low before it samples `dreq` again, so each unit has its own request.
- R10: While the channel is enabled and `dreq` is low, no bus request is raised.
- R11: After reset, `bus_req`, `dack`, `bus_rd`, `bus_wr`, `busy`, `done`, `err` and `irq` are all low.
- R12: Register select values are 0 source address, 1 destination address, 2 count and 3 control. The control word bits are [0] go, [3:1] source type, [6:4] destination type, [8:7] size, [10:9] source step, [12:11] destination step and [13] burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| busy | output | 1 | Channel enabled or bus sequence in progress |
| done | output | 1 | Count expired |
| err | output | 1 | Last start was rejected |
| irq | output | 1 | One-cycle completion pulse |
| dreq | input | 1 | Device transfer request |
| dack | output | 1 | Acknowledge strobe for the device endpoint |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Access address |
| bus_rd | output | 1 | Read access |
| bus_wr | output | 1 | Write access |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |

## Verification
The bench tries both directions of the fly-by style. A design that mixed up which end receives the acknowledge would show the wrong access direction or an address that should not move. It pairs each two-cycle write with the data of the read before it, which catches a holding register that is stale or skipped. It counts rising edges of the bus request to tell burst from cycle-steal, so a channel that keeps the bus or drops it at the wrong time is caught. It also tries rejected starts (a bad pairing, a peripheral size mismatch, a zero count) while `dreq` is high. A design that let any of them through would produce a bus access for which the scoreboard has no entry.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] EP_ACKDEV = 3'd0;
  localparam logic [2:0] EP_XMEM   = 3'd1;
  localparam logic [2:0] EP_XDEV   = 3'd2;
  localparam logic [2:0] EP_PERI   = 3'd3;
  localparam logic [2:0] EP_IMEM   = 3'd4;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam logic [1:0] STEP_FIX = 2'd0;
  localparam logic [1:0] STEP_INC = 2'd1;
  localparam logic [1:0] STEP_DEC = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_FLY, ST_REL
  } st_t;
endpackage

// File: rtl/dma_pair_check.sv
module dma_pair_check
  import dma_pkg::*;
#(
  parameter logic [1:0] PERIPH_SIZE = 2'd1
) (
  input  logic [2:0] src_t,
  input  logic [2:0] dst_t,
  input  logic [1:0] size,
  output logic       ok,
  output logic       single
);
  logic src_ack, dst_ack, src_ext, dst_ext, valid, pair_ok, size_ok, has_peri;

  always_comb begin
    src_ack  = (src_t == EP_ACKDEV);
    dst_ack  = (dst_t == EP_ACKDEV);
    src_ext  = (src_t == EP_XMEM) || (src_t == EP_XDEV);
    dst_ext  = (dst_t == EP_XMEM) || (dst_t == EP_XDEV);
    valid    = (src_t <= EP_IMEM) && (dst_t <= EP_IMEM);
    pair_ok  = (src_ack && dst_ext) || (dst_ack && src_ext) || (!src_ack && !dst_ack);
    has_peri = (src_t == EP_PERI) || (dst_t == EP_PERI);
    size_ok  = (size <= 2'd2) && (!has_peri || size == PERIPH_SIZE);
    ok       = valid && pair_ok && size_ok;
    single   = src_ack || dst_ack;
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] next
);
  logic [AW-1:0] delta;

  always_comb begin
    delta = AW'(1) << size;
    case (mode)
      STEP_INC: next = addr + delta;
      STEP_DEC: next = addr - delta;
      default:  next = addr;
    endcase
  end
endmodule

// File: rtl/dma_flyby_ch.sv
module dma_flyby_ch
  import dma_pkg::*;
#(
  parameter int         AW          = 32,
  parameter int         DW          = 32,
  parameter int         CW          = 16,
  parameter logic [1:0] PERIPH_SIZE = 2'd1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          irq,
  input  logic          dreq,
  output logic          dack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  st_t           state;
  logic [AW-1:0] src_a, dst_a, src_nx, dst_nx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;
  logic [2:0]    src_t, dst_t;
  logic [1:0]    size_r, src_m, dst_m;
  logic          burst_r, single_r, en_r, done_r, err_r, irq_r;
  logic          pair_ok, pair_single, go_wr, step_src, step_dst;

  // legality of the pairing carried by the control word being written
  dma_pair_check #(.PERIPH_SIZE(PERIPH_SIZE)) i_pair (
    .src_t (cfg_wdata[3:1]),
    .dst_t (cfg_wdata[6:4]),
    .size  (cfg_wdata[8:7]),
    .ok    (pair_ok),
    .single(pair_single)
  );

  dma_addr_step #(.AW(AW)) i_src_step (
    .addr(src_a), .mode(src_m), .size(size_r), .next(src_nx)
  );
  dma_addr_step #(.AW(AW)) i_dst_step (
    .addr(dst_a), .mode(dst_m), .size(size_r), .next(dst_nx)
  );

  assign go_wr    = cfg_we && (cfg_sel == SEL_CTL) && cfg_wdata[0];
  // fly-by only moves the memory-side address; two-cycle moves both
  assign step_src = !single_r || (dst_t == EP_ACKDEV);
  assign step_dst = !single_r || (src_t == EP_ACKDEV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      src_a    <= '0;
      dst_a    <= '0;
      cnt      <= '0;
      hold     <= '0;
      src_t    <= '0;
      dst_t    <= '0;
      size_r   <= '0;
      src_m    <= '0;
      dst_m    <= '0;
      burst_r  <= 1'b0;
      single_r <= 1'b0;
      en_r     <= 1'b0;
      done_r   <= 1'b0;
      err_r    <= 1'b0;
      irq_r    <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          SEL_SRC: src_a <= cfg_wdata;
          SEL_DST: dst_a <= cfg_wdata;
          SEL_CNT: cnt   <= cfg_wdata[CW-1:0];
          default: begin
            src_t    <= cfg_wdata[3:1];
            dst_t    <= cfg_wdata[6:4];
            size_r   <= cfg_wdata[8:7];
            src_m    <= cfg_wdata[10:9];
            dst_m    <= cfg_wdata[12:11];
            burst_r  <= cfg_wdata[13];
            single_r <= pair_single;
          end
        endcase
      end
      if (go_wr) begin
        if (pair_ok && cnt != '0) begin
          en_r   <= 1'b1;
          done_r <= 1'b0;
          err_r  <= 1'b0;
        end else begin
          en_r  <= 1'b0;
          err_r <= 1'b1;
        end
      end
      case (state)
        ST_IDLE: if (en_r && dreq) state <= ST_REQ;
        ST_REQ:  if (bus_gnt) state <= single_r ? ST_FLY : ST_RD;
        ST_RD: begin
          hold  <= bus_rdata;
          state <= ST_WR;
        end
        ST_WR, ST_FLY: begin
          if (step_src) src_a <= src_nx;
          if (step_dst) dst_a <= dst_nx;
          cnt <= cnt - CNT_ONE;
          if (cnt == CNT_ONE) begin
            en_r   <= 1'b0;
            done_r <= 1'b1;
            irq_r  <= 1'b1;
            state  <= ST_REL;
          end else if (burst_r) begin
            state <= single_r ? ST_FLY : ST_RD;
          end else begin
            state <= ST_REL;
          end
        end
        ST_REL:  if (!bus_gnt) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = (state == ST_REQ) || (state == ST_RD) || (state == ST_WR) || (state == ST_FLY);
    dack      = (state == ST_FLY);
    bus_rd    = (state == ST_RD) || (dack && dst_t == EP_ACKDEV);
    bus_wr    = (state == ST_WR) || (dack && src_t == EP_ACKDEV);
    bus_wdata = (state == ST_WR) ? hold : '0;
    case (state)
      ST_RD:   bus_addr = src_a;
      ST_WR:   bus_addr = dst_a;
      ST_FLY:  bus_addr = (dst_t == EP_ACKDEV) ? src_a : dst_a;
      default: bus_addr = '0;
    endcase
  end

  assign bus_size = size_r;
  assign busy     = en_r || (state != ST_IDLE);
  assign done     = done_r;
  assign err      = err_r;
  assign irq      = irq_r;

  // R5
  dack_dual_chk: assert property (@(posedge clk) disable iff (rst) dack |-> single_r);
  // R4
  access_gnt_chk: assert property (@(posedge clk) disable iff (rst) (bus_rd || bus_wr) |-> bus_gnt);
  // R1
  bad_start_chk: assert property (@(posedge clk) disable iff (rst)
    (go_wr && !pair_ok) |=> (err_r && !en_r));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq_r |=> !irq_r);
  // R7
  irq_count_chk: assert property (@(posedge clk) disable iff (rst) irq_r |-> (cnt == '0 && done_r));
  // R10
  no_dreq_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !dreq) |=> !bus_req);
endmodule

// File: tb/test_dma_flyby_ch.sv
module test_dma_flyby_ch;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, done, err, irq, dreq, dack, bus_req, bus_gnt, bus_rd, bus_wr;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        dk;
    logic [31:0] addr;
    logic [31:0] data;
    logic        chk;
  } acc_t;

  acc_t exp_q[$];
  int   errors = 0;
  int   checks = 0;
  int   irq_cnt = 0;
  int   rises = 0;
  logic req_prev = 1'b0;
  bit   finished = 0;

  dma_flyby_ch i_dma_flyby_ch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .err(err), .irq(irq), .dreq(dreq), .dack(dack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  // grant follows request one cycle later; read data derived from the address
  always_ff @(posedge clk) bus_gnt <= rst ? 1'b0 : bus_req;
  assign bus_rdata = bus_addr ^ KEY;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected access per observed access
  always @(negedge clk) begin
    if (!rst) begin
      if (irq) irq_cnt++;
      if (bus_req && !req_prev) rises++;
      req_prev = bus_req;
      if (bus_rd || bus_wr) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected access", bus_addr, 32'hFFFF_FFFF);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(bus_rd == e.rd && bus_wr == e.wr, "R4/R5 access kind", {30'd0, bus_rd, bus_wr}, {30'd0, e.rd, e.wr});
          chk(dack == e.dk, "R4/R5 dack", {31'd0, dack}, {31'd0, e.dk});
          chk(bus_addr == e.addr, "R6 address", bus_addr, e.addr);
          if (e.chk) chk(bus_wdata == e.data, "R5 write data", bus_wdata, e.data);
        end
      end
    end
  end

  function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m, input logic [1:0] sz);
    if (m == 2'd1) return a + (32'd1 << sz);
    if (m == 2'd2) return a - (32'd1 << sz);
    return a;
  endfunction

  function automatic logic [31:0] ctl(input logic [2:0] st, input logic [2:0] dt, input logic [1:0] sz,
                                      input logic [1:0] sm, input logic [1:0] dm, input logic b);
    return {18'd0, b, dm, sm, sz, dt, st, 1'b1};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_dual(input logic [31:0] s, input logic [31:0] d, input int n,
                           input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm);
    logic [31:0] sa = s, da = d;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{rd: 1'b1, wr: 1'b0, dk: 1'b0, addr: sa, data: 32'd0, chk: 1'b0});
      exp_q.push_back('{rd: 1'b0, wr: 1'b1, dk: 1'b0, addr: da, data: sa ^ KEY, chk: 1'b1});
      sa = step(sa, sm, sz);
      da = step(da, dm, sz);
    end
  endtask

  task automatic push_fly(input logic [31:0] a, input int n, input logic is_wr,
                          input logic [1:0] sz, input logic [1:0] m);
    logic [31:0] aa = a;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{rd: !is_wr, wr: is_wr, dk: 1'b1, addr: aa, data: 32'd0, chk: 1'b0});
      aa = step(aa, m, sz);
    end
  endtask

  task automatic start(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n, input logic [31:0] c);
    irq_cnt = 0;
    rises = 0;
    wr_reg(2'd0, s);
    wr_reg(2'd1, d);
    wr_reg(2'd2, n);
    wr_reg(2'd3, c);
  endtask

  task automatic finish_run(input string req, input int exp_rises);
    int t = 0;
    while (busy && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(!busy && done, "R7 done after last unit", {30'd0, busy, done}, 32'd1);
    chk(irq_cnt == 1, "R7 single irq pulse", irq_cnt, 32'd1);
    chk(exp_q.size() == 0, "R5 all accesses seen", exp_q.size(), 32'd0);
    chk(rises == exp_rises, req, rises, exp_rises);
  endtask

  task automatic reject(input string req);
    repeat (8) @(negedge clk);
    chk(err && !busy && !bus_req, req, {29'd0, err, busy, bus_req}, 32'd4);
    chk(irq_cnt == 0, req, irq_cnt, 32'd0);
  endtask

  initial begin
    dreq = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!bus_req && !dack && !bus_rd && !bus_wr && !busy && !done && !err && !irq, "R11 reset state",
        {24'd0, bus_req, dack, bus_rd, bus_wr, busy, done, err, irq}, 32'd0);

    // R5 R6 R8: two-cycle burst, external memory -> on-chip memory, long, both increment
    push_dual(32'h1000, 32'h2000, 3, 2'd2, 2'd1, 2'd1);
    start(32'h1000, 32'h2000, 3, ctl(3'd1, 3'd4, 2'd2, 2'd1, 2'd1, 1'b1));
    finish_run("R8 burst holds request", 1);

    // R9 R6: two-cycle cycle-steal, byte, source decrements, destination fixed
    push_dual(32'h3010, 32'h4000, 2, 2'd0, 2'd2, 2'd0);
    start(32'h3010, 32'h4000, 2, ctl(3'd2, 3'd1, 2'd0, 2'd2, 2'd0, 1'b0));
    finish_run("R9 cycle-steal request per unit", 2);

    // R4: fly-by, device -> external memory, word, destination increments
    push_fly(32'h5000, 2, 1'b1, 2'd1, 2'd1);
    start(32'h9999, 32'h5000, 2, ctl(3'd0, 3'd1, 2'd1, 2'd1, 2'd1, 1'b0));
    finish_run("R9 fly-by cycle-steal", 2);

    // R4: fly-by, memory-mapped device -> device, long, source decrements, burst
    push_fly(32'h6000, 2, 1'b0, 2'd2, 2'd2);
    start(32'h6000, 32'h7777, 2, ctl(3'd2, 3'd0, 2'd2, 2'd2, 2'd1, 1'b1));
    finish_run("R8 fly-by burst", 1);

    // R2: peripheral with permitted size runs
    push_dual(32'h7000, 32'h8000, 1, 2'd1, 2'd0, 2'd0);
    start(32'h7000, 32'h8000, 1, ctl(3'd3, 3'd4, 2'd1, 2'd0, 2'd0, 1'b1));
    finish_run("R2 peripheral legal size", 1);

    // R2: peripheral with other size rejected
    start(32'h7000, 32'h8000, 1, ctl(3'd3, 3'd4, 2'd2, 2'd0, 2'd0, 1'b1));
    reject("R2 peripheral size mismatch");

    // R1: device with on-chip memory rejected
    start(32'h0, 32'h8000, 2, ctl(3'd0, 3'd4, 2'd2, 2'd1, 2'd1, 1'b0));
    reject("R1 device to on-chip memory");

    // R1: device with device rejected
    start(32'h0, 32'h0, 2, ctl(3'd0, 3'd0, 2'd2, 2'd1, 2'd1, 1'b0));
    reject("R1 device to device");

    // R1: invalid type code rejected
    start(32'h0, 32'h0, 2, ctl(3'd6, 3'd1, 2'd2, 2'd1, 2'd1, 1'b0));
    reject("R1 invalid code");

    // R3: zero count rejected
    start(32'h100, 32'h200, 0, ctl(3'd1, 3'd1, 2'd2, 2'd1, 2'd1, 1'b1));
    reject("R3 zero count");

    // R10 R12: enabled with dreq low raises no request until dreq rises
    dreq = 1'b0;
    start(32'hA000, 32'hB000, 1, ctl(3'd1, 3'd2, 2'd0, 2'd1, 2'd1, 1'b0));
    repeat (10) @(negedge clk);
    chk(busy && !bus_req && !err, "R10 waits for dreq", {29'd0, busy, bus_req, err}, 32'd4);
    push_dual(32'hA000, 32'hB000, 1, 2'd0, 2'd1, 2'd1);
    dreq = 1'b1;
    finish_run("R12 run after dreq", 1);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule